// File: doc/BRIEF.md
# DDR Mode Register Capture Unit

This unit is the device-side front end that watches the command pins of a DDR SDRAM for a mode-set command and loads the address bus into one of two configuration registers. The bank-address bit picks the target: the main mode register when low, the extended mode register when high. The main register's low bits are decoded into the burst length, the burst ordering and the read latency. The latency is given in half-cycles, so the 2.5-cycle setting is a plain integer.

A write lands only when every bank reports idle and the clock enable was high both on the command edge and on the edge before it. After an accepted write the unit blocks further mode-set commands for a fixed recovery window. A rejected command leaves both registers untouched and produces a one-cycle error pulse. A delay-locked-loop reset request in the main register comes out as a one-cycle pulse, not as a stored level. A validity flag stays low after reset until the main register receives its first legal write.

Top module: `ddr_modereg_capture`

## Requirements
- R1: A mode-set command has cs_n, ras_n, cas_n and we_n all low at a rising edge. When it is accepted with ba=0, mode_word equals the addr value from that edge in the following cycle.
- R2: An accepted command with ba=1 loads addr into ext_word. mode_word and mode_valid are left unchanged.
- R3: Burst-length code mode_word[2:0] 001, 010 and 011 gives burst_len 2, 4 and 8. Any other code gives burst_len 0 and bl_reserved high. burst_interleave equals mode_word[3].
- R4: Latency code mode_word[6:4] 010, 011 and 110 gives cas_lat_half 4, 6 and 5. Any other code gives cas_lat_half 0 and cl_reserved high.
- R5: A mode-set command is rejected in any of these cases: a bank_idle bit is low, cke is low at the command edge, or cke was low at the preceding edge. A rejected command raises illegal_cmd for exactly the next cycle and changes neither register.
- R6: With ba=0, a command is rejected if addr[7] is 1 or addr[10:9] is nonzero. These bits do not restrict ba=1 writes.
- R7: After an accepted write, busy is high for MRD_CYCLES-1 cycles (one cycle by default). A mode-set command arriving while busy is high is rejected as in R5.
- R8: dll_reset_pulse is high for exactly one cycle after an accepted ba=0 write with addr[8]=1. It stays low after ba=1 writes and after rejected writes.
- R9: mode_valid is low after reset and rises after the first accepted ba=0 write. It then stays high. bl_reserved and cl_reserved stay low while mode_valid is low.
- R10: Pin patterns other than the mode-set command are ignored: illegal_cmd stays low and both registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Register select: 0 main, 1 extended |
| addr | input | ADDR_W | Address bus with the register contents |
| bank_idle | input | NUM_BANKS | Per-bank precharged status |
| mode_word | output | ADDR_W | Stored main mode register |
| ext_word | output | ADDR_W | Stored extended mode register |
| mode_valid | output | 1 | Main register has been written |
| burst_len | output | 4 | Decoded burst length (2, 4, 8 or 0) |
| burst_interleave | output | 1 | Interleaved burst ordering |
| cas_lat_half | output | 3 | Read latency in half-cycles (4, 5, 6 or 0) |
| bl_reserved | output | 1 | Stored burst-length code is reserved |
| cl_reserved | output | 1 | Stored latency code is reserved |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| illegal_cmd | output | 1 | One-cycle pulse for a rejected command |
| busy | output | 1 | Recovery window after a write |

## Verification
The bench sends two writes on consecutive edges. A design without the recovery window would overwrite the register with the second word. It clears cke for one edge and then issues a command with cke high. A design that checks only the current cke would accept that command. It uses the 2.5-cycle latency code, which a design mapping codes by rank would report as 3, and reserved codes on both fields, which would otherwise look like a legal length. It also gives an extended write a set DLL bit and gives a main write a set test bit. A design without the bank-select split would pulse or reject on the wrong register.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  localparam int unsigned BT_BIT   = 3;
  localparam int unsigned TM_BIT   = 7;
  localparam int unsigned DLL_BIT  = 8;
  localparam int unsigned RFU_LO   = 9;
  localparam int unsigned FIELD_W  = 7;

  function automatic logic [3:0] bl_from_code(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'b001:  r = 4'd2;
      3'b010:  r = 4'd4;
      3'b011:  r = 4'd8;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] cl_half_from_code(input logic [2:0] code);
    logic [2:0] r;
    case (code)
      3'b010:  r = 3'd4;
      3'b011:  r = 3'd6;
      3'b110:  r = 3'd5;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mrc_busy_timer.sv
module mrc_busy_timer #(
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(MRD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MRD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R7

endmodule

// File: rtl/mrc_cmd_decode.sv
module mrc_cmd_decode #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic                  ba,
  input  logic                  tm_bit,
  input  logic [ADDR_W-10:0]    rfu_bits,
  input  logic [NUM_BANKS-1:0]  bank_idle,
  input  logic                  busy,
  output logic                  cmd_seen,
  output logic                  set_main,
  output logic                  set_ext,
  output logic                  reject
);
  logic cke_q, cke_d;
  logic clk_ok, banks_ok, fields_ok, accept;

  always_comb cke_d = cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  always_comb begin
    cmd_seen  = !cs_n && !ras_n && !cas_n && !we_n;
    clk_ok    = cke && cke_q;
    banks_ok  = &bank_idle;
    fields_ok = ba || (!tm_bit && (rfu_bits == '0));
    accept    = clk_ok && banks_ok && fields_ok && !busy;
    set_main  = cmd_seen && accept && !ba;
    set_ext   = cmd_seen && accept && ba;
    reject    = cmd_seen && !accept;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_main, set_ext, reject}) <= 1); // R5

endmodule

// File: rtl/mrc_field_decode.sv
module mrc_field_decode
  import mrc_pkg::*;
(
  input  logic [FIELD_W-1:0] fld,
  input  logic               valid,
  output logic [3:0]         burst_len,
  output logic               burst_interleave,
  output logic [2:0]         cas_lat_half,
  output logic               bl_reserved,
  output logic               cl_reserved
);
  always_comb begin
    burst_len        = bl_from_code(fld[2:0]);
    burst_interleave = fld[BT_BIT];
    cas_lat_half     = cl_half_from_code(fld[6:4]);
    bl_reserved      = valid && (burst_len == 4'd0);
    cl_reserved      = valid && (cas_lat_half == 3'd0);
  end
endmodule

// File: rtl/ddr_modereg_capture.sv
module ddr_modereg_capture
  import mrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic [ADDR_W-1:0]    mode_word,
  output logic [ADDR_W-1:0]    ext_word,
  output logic                 mode_valid,
  output logic [3:0]           burst_len,
  output logic                 burst_interleave,
  output logic [2:0]           cas_lat_half,
  output logic                 bl_reserved,
  output logic                 cl_reserved,
  output logic                 dll_reset_pulse,
  output logic                 illegal_cmd,
  output logic                 busy
);
  localparam int unsigned NUM_SLOTS = 2;

  logic cmd_seen, set_main, set_ext, reject;
  logic [NUM_SLOTS-1:0] slot_wr;
  logic [ADDR_W-1:0] slot_word [NUM_SLOTS];

  logic valid_q, valid_d;
  logic illegal_q, illegal_d;
  logic dll_q, dll_d;

  mrc_cmd_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .tm_bit    (addr[TM_BIT]),
    .rfu_bits  (addr[ADDR_W-1:RFU_LO]),
    .bank_idle (bank_idle),
    .busy      (busy),
    .cmd_seen  (cmd_seen),
    .set_main  (set_main),
    .set_ext   (set_ext),
    .reject    (reject)
  );

  mrc_busy_timer #(
    .MRD_CYCLES (MRD_CYCLES)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (set_main || set_ext),
    .busy  (busy)
  );

  assign slot_wr = {set_ext, set_main};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] word_q, word_d;

    always_comb word_d = slot_wr[s] ? addr : word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign slot_word[s] = word_q;
  end

  assign mode_word = slot_word[0];
  assign ext_word  = slot_word[1];

  always_comb begin
    valid_d   = valid_q || set_main;
    illegal_d = reject;
    dll_d     = set_main && addr[DLL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      dll_q     <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      dll_q     <= dll_d;
    end
  end

  assign mode_valid      = valid_q;
  assign illegal_cmd     = illegal_q;
  assign dll_reset_pulse = dll_q;

  mrc_field_decode u_fields (
    .fld              (mode_word[FIELD_W-1:0]),
    .valid            (valid_q),
    .burst_len        (burst_len),
    .burst_interleave (burst_interleave),
    .cas_lat_half     (cas_lat_half),
    .bl_reserved      (bl_reserved),
    .cl_reserved      (cl_reserved)
  );

  AST_REJECT_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> (mode_word == $past(mode_word)) && (ext_word == $past(ext_word))); // R5
  AST_EXT_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && ba) |=> $stable(mode_word)); // R2
  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_seen) |=> illegal_cmd); // R7
  AST_DLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse); // R8
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> mode_valid); // R9
  AST_BL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_len)); // R3
  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && !cl_reserved) |-> (cas_lat_half >= 3'd4 && cas_lat_half <= 3'd6)); // R4
  AST_NO_CMD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_seen |=> !illegal_cmd); // R10

endmodule

// File: tb/ddr_modereg_capture_tb_top.sv
`timescale 1ns/1ps
module ddr_modereg_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic ba = 1'b0;
  logic [10:0] addr = '0;
  logic [3:0] bank_idle = 4'hF;
  logic [10:0] mode_word, ext_word;
  logic mode_valid, burst_interleave, bl_reserved, cl_reserved;
  logic dll_reset_pulse, illegal_cmd, busy;
  logic [3:0] burst_len;
  logic [2:0] cas_lat_half;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ddr_modereg_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_idle(bank_idle),
    .mode_word(mode_word), .ext_word(ext_word), .mode_valid(mode_valid),
    .burst_len(burst_len), .burst_interleave(burst_interleave),
    .cas_lat_half(cas_lat_half), .bl_reserved(bl_reserved),
    .cl_reserved(cl_reserved), .dll_reset_pulse(dll_reset_pulse),
    .illegal_cmd(illegal_cmd), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_pins(input logic [3:0] p, input logic b, input logic [10:0] a);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    addr = a;
  endtask

  // drive at a falling edge, capture at the next rising edge, sample at the following falling edge
  task automatic send(input logic [3:0] p, input logic b, input logic [10:0] a);
    @(negedge clk);
    set_pins(p, b, a);
    @(negedge clk);
    set_pins(4'b0111, 1'b0, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 valid after reset", mode_valid, 0);
    check("R9 bl_reserved low", bl_reserved, 0);
    check("R9 cl_reserved low", cl_reserved, 0);
    check("R5 illegal after reset", illegal_cmd, 0);
    check("R7 busy after reset", busy, 0);
  endtask

  task automatic t_ext_first();
    send(4'b0000, 1'b1, 11'h102);
    check("R2 ext_word", ext_word, 11'h102);
    check("R2 mode_word held", mode_word, 0);
    check("R9 valid stays low", mode_valid, 0);
    check("R8 no dll on ext", dll_reset_pulse, 0);
    idle(2);
  endtask

  task automatic t_main_write();
    send(4'b0000, 1'b0, 11'h032);
    check("R1 mode_word", mode_word, 11'h032);
    check("R9 valid set", mode_valid, 1);
    check("R3 bl4", burst_len, 4);
    check("R3 sequential", burst_interleave, 0);
    check("R4 cl3", cas_lat_half, 6);
    check("R7 busy high", busy, 1);
    check("R1 no illegal", illegal_cmd, 0);
    idle(1);
    check("R7 busy cleared", busy, 0);
    idle(1);
  endtask

  task automatic t_busy();
    @(negedge clk);
    set_pins(4'b0000, 1'b0, 11'h032);
    @(negedge clk);
    set_pins(4'b0000, 1'b0, 11'h023);
    @(negedge clk);
    set_pins(4'b0111, 1'b0, '0);
    check("R7 busy reject", illegal_cmd, 1);
    check("R7 word held", mode_word, 11'h032);
    idle(1);
    check("R5 pulse one cycle", illegal_cmd, 0);
    send(4'b0000, 1'b0, 11'h023);
    check("R7 accepted after window", mode_word, 11'h023);
    check("R3 bl8", burst_len, 8);
    check("R4 cl2", cas_lat_half, 4);
    idle(2);
  endtask

  task automatic t_half_latency_dll();
    send(4'b0000, 1'b0, 11'h169);
    check("R1 word", mode_word, 11'h169);
    check("R3 bl2", burst_len, 2);
    check("R3 interleave", burst_interleave, 1);
    check("R4 cl2.5", cas_lat_half, 5);
    check("R8 dll pulse", dll_reset_pulse, 1);
    idle(1);
    check("R8 dll one cycle", dll_reset_pulse, 0);
    idle(1);
  endtask

  task automatic t_reserved();
    send(4'b0000, 1'b0, 11'h017);
    check("R3 bl reserved 111", bl_reserved, 1);
    check("R3 bl zero", burst_len, 0);
    check("R4 cl reserved 001", cl_reserved, 1);
    check("R4 cl zero", cas_lat_half, 0);
    idle(2);
    send(4'b0000, 1'b0, 11'h044);
    check("R3 bl reserved 100", bl_reserved, 1);
    check("R4 cl reserved 100", cl_reserved, 1);
    idle(2);
    send(4'b0000, 1'b0, 11'h032);
    check("R3 bl legal again", bl_reserved, 0);
    check("R4 cl legal again", cl_reserved, 0);
    idle(2);
  endtask

  task automatic t_not_ready();
    bank_idle = 4'b1011;
    send(4'b0000, 1'b0, 11'h023);
    check("R5 bank active reject", illegal_cmd, 1);
    check("R5 word held", mode_word, 11'h032);
    bank_idle = 4'hF;
    idle(2);
    @(negedge clk);
    cke = 1'b0;
    set_pins(4'b0000, 1'b0, 11'h023);
    @(negedge clk);
    set_pins(4'b0111, 1'b0, '0);
    cke = 1'b1;
    check("R5 cke low reject", illegal_cmd, 1);
    check("R5 word held cke", mode_word, 11'h032);
    idle(1);
    @(negedge clk);
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    set_pins(4'b0000, 1'b1, 11'h055);
    @(negedge clk);
    set_pins(4'b0111, 1'b0, '0);
    check("R5 cke prev low reject", illegal_cmd, 1);
    check("R5 ext held", ext_word, 11'h102);
    idle(2);
  endtask

  task automatic t_field_guard();
    send(4'b0000, 1'b0, 11'h0B2);
    check("R6 test bit reject", illegal_cmd, 1);
    check("R6 word held a7", mode_word, 11'h032);
    idle(2);
    send(4'b0000, 1'b0, 11'h432);
    check("R6 high bit reject", illegal_cmd, 1);
    check("R6 word held a10", mode_word, 11'h032);
    idle(2);
    send(4'b0000, 1'b1, 11'h580);
    check("R6 ext not guarded", illegal_cmd, 0);
    check("R6 ext word", ext_word, 11'h580);
    check("R8 no dll on ext a8", dll_reset_pulse, 0);
    idle(2);
  endtask

  task automatic t_other_cmds();
    send(4'b0001, 1'b0, 11'h023);
    check("R10 we high ignored", illegal_cmd, 0);
    check("R10 word held", mode_word, 11'h032);
    idle(2);
    send(4'b1000, 1'b0, 11'h023);
    check("R10 cs high ignored", illegal_cmd, 0);
    check("R10 word held cs", mode_word, 11'h032);
    check("R10 ext held", ext_word, 11'h580);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    set_pins(4'b0111, 1'b0, '0);
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_ext_first();
    t_main_write();
    t_busy();
    t_half_latency_dll();
    t_reserved();
    t_not_ready();
    t_field_guard();
    t_other_cmds();
    finish_run();
  end
endmodule